// File: doc/BRIEF.md
# Two-Stage Serial Bit-Rate Generator

This block derives the bit clock of a synchronous serial master from a much faster core clock. The division happens in two cascaded stages. The first stage is a prescaler that only accepts even ratios. The second stage divides its output again by a programmable rate factor. The resulting bit clock runs at core / (prescale × (1 + rate)).

The frame engine asks for a clock by holding a run request. It then follows the clock through two one-cycle strobes, one for each rising and one for each falling edge. While no transfer is running, the bit clock rests low. When the run request is removed, the clock stops only at a period boundary, so no shortened pulse ever appears. An enable input gates the whole block.

The divider settings are captured when a transfer starts. Writes to them during a transfer therefore cannot distort a period that is already in progress.

Top module: `serial_rate_gen`

## Requirements
- R1: The prescale ratio P is the prescale input with bit 0 forced to 0. Programmed values 0 and 1 give P = 2. Valid ratios are the even values 2 to 254.
- R2: The second stage multiplies the period by (1 + rate), with the rate input taking values 0 to 255.
- R3: Let H = P × (1 + rate) / 2. The clock edge that first sees run high (with enable high) starts a transfer. `sclk` goes high H edges after that start edge and low H edges after that. Each full bit-clock period lasts P × (1 + rate) core cycles.
- R4: Whenever no transfer is active, `sclk` is low and both strobes are low. This includes during and after reset.
- R5: While enable is low, no transfer starts. If enable falls during a transfer, `sclk` is low from the next edge on and the transfer is abandoned.
- R6: `rise_stb` is high for exactly the one cycle in which `sclk` is first high. `fall_stb` is high for exactly the one cycle in which `sclk` is first low. `sclk` never changes without the matching strobe.
- R7: A rising edge is produced only if run is still high at the edge where it falls due. If run is low at that edge, the block goes idle instead. A high phase that has already begun always completes its full H cycles.
- R8: The prescale and rate inputs are captured at the start edge. Changing them during a transfer has no effect on that transfer's timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low reset |
| en | input | 1 | Block enable |
| presc | input | 8 | Prescale ratio (bit 0 ignored) |
| scr | input | 8 | Second-stage rate value; divides by 1 + value |
| run | input | 1 | Transfer request from the frame engine |
| sclk | output | 1 | Serial bit clock, idle low |
| rise_stb | output | 1 | One-cycle strobe on each rising bit-clock edge |
| fall_stb | output | 1 | One-cycle strobe on each falling bit-clock edge |

## Verification
All timing is measured in core-clock edges counted from the start edge, which is the first edge that registers run.

- The i-th rise is due at edge (2i+1)·H and the i-th fall at edge (2i+2)·H. The bench samples each of these on the falling edge that follows, so the cycle index it compares is exactly the edge count.
- When run is dropped after sample k, the rises expected are those with (2i+1)·H ≤ k. The bench then watches 2H more cycles to confirm that nothing further happens.
- A drop of enable is due to show on `sclk` at the very next edge.

// File: rtl/srg_pkg.sv
package srg_pkg;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } phase_e;

endpackage

// File: rtl/srg_prescale.sv
module srg_prescale #(
    parameter int unsigned W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         active,
    input  logic [W-1:0] lim,
    output logic         tick
);

    typedef struct packed {
        logic [W-1:0] cnt;
    } st_t;

    st_t q, d;

    always_comb begin
        d = q;
        tick = active && (q.cnt == lim);
        if (!active) begin
            d.cnt = '0;
        end else if (tick) begin
            d.cnt = '0;
        end else begin
            d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    // Half-ratio counter never passes its latched limit during a transfer
    p_cnt_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (q.cnt <= lim));

endmodule

// File: rtl/srg_rate.sv
module srg_rate #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         active,
    input  logic         tick,
    input  logic [W-1:0] lim,
    output logic         toggle
);

    typedef struct packed {
        logic [W-1:0] cnt;
    } st_t;

    st_t q, d;

    always_comb begin
        d = q;
        toggle = active && tick && (q.cnt == lim);
        if (!active) begin
            d.cnt = '0;
        end else if (tick) begin
            if (q.cnt == lim) begin
                d.cnt = '0;
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    // Tick counter stays within 0..rate during a transfer
    p_rate_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (q.cnt <= lim));

    // Second stage only advances on a first-stage tick
    p_rate_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (active && $past(active) && (q.cnt != $past(q.cnt))) |-> $past(tick));

endmodule

// File: rtl/srg_ctrl.sv
module srg_ctrl
    import srg_pkg::*;
#(
    parameter int unsigned PW = 8,
    parameter int unsigned SW = 8,
    localparam int unsigned HW = PW - 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          run,
    input  logic [PW-1:0] presc,
    input  logic [SW-1:0] scr,
    input  logic          toggle,
    output logic          active,
    output logic [HW-1:0] half_lim,
    output logic [SW-1:0] rate_lim,
    output logic          sclk,
    output logic          rise,
    output logic          fall
);

    typedef struct packed {
        phase_e        phase;
        logic          sclk;
        logic          rise;
        logic          fall;
        logic [HW-1:0] half;
        logic [SW-1:0] rate;
    } st_t;

    st_t q, d;

    // Terminal count of the half-ratio counter: (P/2) - 1, with P even and >= 2
    function automatic logic [HW-1:0] half_of(input logic [PW-1:0] v);
        logic [PW-1:0] h;
        h = v >> 1;
        if (h == '0) begin
            return '0;
        end
        return HW'(h - 1'b1);
    endfunction

    always_comb begin
        d = q;
        d.rise = 1'b0;
        d.fall = 1'b0;
        if (!en) begin
            d.phase = PH_IDLE;
            d.sclk  = 1'b0;
        end else if (q.phase == PH_IDLE) begin
            if (run) begin
                d.phase = PH_RUN;
                d.sclk  = 1'b0;
                d.half  = half_of(presc);
                d.rate  = scr;
            end
        end else if (toggle) begin
            if (q.sclk) begin
                d.sclk = 1'b0;
                d.fall = 1'b1;
            end else if (run) begin
                d.sclk = 1'b1;
                d.rise = 1'b1;
            end else begin
                d.phase = PH_IDLE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign active   = (q.phase == PH_RUN);
    assign half_lim = q.half;
    assign rate_lim = q.rate;
    assign sclk     = q.sclk;
    assign rise     = q.rise;
    assign fall     = q.fall;

    p_idle_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (q.phase == PH_IDLE) |-> !q.sclk);

    p_en_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!q.sclk && q.phase == PH_IDLE));

    p_sclk_on_toggle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (q.sclk != $past(q.sclk)) |-> ($past(toggle) || !$past(en)));

    p_one_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({q.rise, q.fall}));

    p_rise_needs_run_r7: assert property (@(posedge clk) disable iff (!rst_n)
        q.rise |-> ($past(run) && $past(toggle)));

    p_cfg_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (active && $past(active)) |-> ($stable(q.half) && $stable(q.rate)));

endmodule

// File: rtl/serial_rate_gen.sv
module serial_rate_gen #(
    parameter int unsigned PW = 8,
    parameter int unsigned SW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [PW-1:0] presc,
    input  logic [SW-1:0] scr,
    input  logic          run,
    output logic          sclk,
    output logic          rise_stb,
    output logic          fall_stb
);

    localparam int unsigned HW = PW - 1;

    logic          active;
    logic [HW-1:0] half_lim;
    logic [SW-1:0] rate_lim;
    logic          tick;
    logic          toggle;

    srg_ctrl #(
        .PW(PW),
        .SW(SW)
    ) i_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .run      (run),
        .presc    (presc),
        .scr      (scr),
        .toggle   (toggle),
        .active   (active),
        .half_lim (half_lim),
        .rate_lim (rate_lim),
        .sclk     (sclk),
        .rise     (rise_stb),
        .fall     (fall_stb)
    );

    srg_prescale #(
        .W(HW)
    ) i_prescale (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (active),
        .lim    (half_lim),
        .tick   (tick)
    );

    srg_rate #(
        .W(SW)
    ) i_rate (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (active),
        .tick   (tick),
        .lim    (rate_lim),
        .toggle (toggle)
    );

endmodule

// File: tb/test_serial_rate_gen.sv
module test_serial_rate_gen;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       en;
    logic [7:0] presc;
    logic [7:0] scr;
    logic       run;
    logic       sclk;
    logic       rise_stb;
    logic       fall_stb;

    int checks   = 0;
    int failures = 0;

    always #4 clk = ~clk;

    serial_rate_gen i_serial_rate_gen (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .presc    (presc),
        .scr      (scr),
        .run      (run),
        .sclk     (sclk),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb)
    );

    task automatic chk(input bit ok, input string what, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    // Half period in core cycles, from R1/R2/R3
    function automatic int half_cycles(input logic [7:0] p, input logic [7:0] s);
        int pe;
        pe = int'(p) & 32'hFE;
        if (pe < 2) pe = 2;
        return (pe / 2) * (int'(s) + 1);
    endfunction

    // One transfer; run dropped after sample kdrop; settings scrambled after start (R8)
    task automatic transfer(input logic [7:0] p, input logic [7:0] s, input int kdrop, input string tag);
        int h, kmax, nrise, nfall, exp_rise;
        bit prev;
        h = half_cycles(p, s);
        kmax = kdrop + 2 * h + 4;
        exp_rise = 0;
        for (int i = 0; (2 * i + 1) * h <= kdrop; i++) exp_rise++;
        @(negedge clk);
        presc = p;
        scr   = s;
        run   = 1'b1;
        prev  = 1'b0;
        nrise = 0;
        nfall = 0;
        for (int k = 0; k <= kmax; k++) begin
            @(negedge clk);
            if (rise_stb) begin
                chk(k == (2 * nrise + 1) * h, $sformatf("%s R3 rise edge", tag), k, (2 * nrise + 1) * h);
                chk(!prev && sclk, $sformatf("%s R6 rise strobe aligned", tag), sclk, 1);
                nrise++;
            end
            if (fall_stb) begin
                chk(k == (2 * nfall + 2) * h, $sformatf("%s R3 fall edge", tag), k, (2 * nfall + 2) * h);
                chk(prev && !sclk, $sformatf("%s R6 fall strobe aligned", tag), sclk, 0);
                nfall++;
            end
            if ((sclk != prev) && !rise_stb && !fall_stb)
                chk(1'b0, $sformatf("%s R6 edge without strobe", tag), sclk, prev);
            prev = sclk;
            if (k == 0) begin
                presc = 8'($urandom);
                scr   = 8'($urandom);
            end
            if (k == kdrop) run = 1'b0;
        end
        chk(nrise == exp_rise, $sformatf("%s R7 rise count", tag), nrise, exp_rise);
        chk(nfall == exp_rise, $sformatf("%s R7 fall count", tag), nfall, exp_rise);
        chk(!sclk && !rise_stb && !fall_stb, $sformatf("%s R4 idle after stop", tag), sclk, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 190000, 0);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int h;
        void'($urandom(32'd4242));
        rst_n = 1'b0;
        en    = 1'b0;
        run   = 1'b0;
        presc = '0;
        scr   = '0;
        repeat (4) @(negedge clk);
        chk(!sclk && !rise_stb && !fall_stb, "R4 idle in reset", sclk, 0);
        rst_n = 1'b1;
        en    = 1'b1;
        repeat (10) @(negedge clk);
        chk(!sclk && !rise_stb && !fall_stb, "R4 idle after reset", sclk, 0);

        // Directed corners
        transfer(8'd0,   8'd0,   5,    "R1 prescale 0");
        transfer(8'd1,   8'd0,   4,    "R1 prescale 1");
        transfer(8'd7,   8'd2,   40,   "R1 odd prescale 7");
        transfer(8'd2,   8'd255, 600,  "R2 rate 255");
        transfer(8'd255, 8'd1,   700,  "R1 R2 prescale 255");
        transfer(8'd254, 8'd3,   1100, "R3 long period");
        transfer(8'd4,   8'd1,   12,   "R7 drop at rise point");
        transfer(8'd4,   8'd1,   13,   "R7 drop in high half");
        transfer(8'd6,   8'd0,   1,    "R7 drop before first rise");
        transfer(8'd10,  8'd4,   100,  "R8 settings scrambled");

        // Constrained random
        for (int n = 0; n < 24; n++) begin
            logic [7:0] p, s;
            int kd;
            p  = 8'($urandom % 64);
            s  = 8'($urandom % 6);
            h  = half_cycles(p, s);
            kd = 1 + int'($urandom % (6 * h));
            transfer(p, s, kd, "R3 random");
        end

        // R5: enable gating and abort
        @(negedge clk);
        en    = 1'b0;
        presc = 8'd4;
        scr   = 8'd1;
        run   = 1'b1;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (sclk || rise_stb || fall_stb)
                chk(1'b0, "R5 activity while disabled", sclk, 0);
        end
        chk(!sclk, "R5 no start while disabled", sclk, 0);
        h  = half_cycles(8'd4, 8'd1);
        en = 1'b1;
        repeat (h + 1) @(negedge clk);
        chk(sclk && rise_stb, "R5 start on enable", sclk, 1);
        en = 1'b0;
        @(negedge clk);
        chk(!sclk && !fall_stb, "R5 abort on enable drop", sclk, 0);
        for (int k = 0; k < 3 * h; k++) begin
            @(negedge clk);
            if (sclk || rise_stb || fall_stb)
                chk(1'b0, "R5 activity after abort", sclk, 0);
        end
        run = 1'b0;
        @(negedge clk);
        en = 1'b1;
        repeat (4) @(negedge clk);
        chk(!sclk && !rise_stb, "R4 idle after abort", sclk, 0);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule